// File: doc/BRIEF.md
# Shift Register Data Path with Automatic FIFO Transfer

This block is the data path of one programmable I/O sequencer between its two shift registers and its two FIFOs. An input shift register gathers 1 to 32 bits per shift-in command and hands full words to a receive FIFO. An output shift register is loaded from a transmit FIFO and releases 1 to 32 bits per shift-out command. Both registers have a saturating bit counter. The sequencer's decoder issues one command per cycle on a strobe interface. The host side writes the transmit FIFO, reads the receive FIFO, and sees the levels of both.

Transfers between registers and FIFOs are either explicit or automatic. Explicit push and pull commands can wait for the threshold and can either block or not block. Automatic transfers fire when a counter reaches its programmed threshold. A command that cannot finish raises `stall` in the same cycle and changes no state, so the decoder can issue it again. A join setting gives all storage to one direction as an eight-entry queue.

Top module: `shiftFifoPath`

## Requirements
- R1: Reset clears both shift registers and both counters, and empties both FIFOs.
- R2: Shift-in (cmdOp 1) of N bits (1..32): shifting left puts the low N bits of cmdData into bits N-1..0 and moves old content up. Shifting right puts them into bits 31..32-N and moves old content down. The counter adds N and saturates at 32.
- R3: Shift-out (cmdOp 2) of N bits returns the top N bits when shifting left, or the bottom N bits when shifting right, right-aligned on shiftOutData. The register shifts and fills with zeros. The counter adds N and saturates at 32.
- R4: Push (cmdOp 3) writes the input register to the receive FIFO and clears the register and its counter. With cmdIfThresh set and the count below pushThresh, push does nothing.
- R5: Pull (cmdOp 4) loads the output register from the transmit FIFO head and clears its counter. With cmdIfThresh set and the count below pullThresh, pull does nothing.
- R6: A blocking push to a full receive FIFO raises stall and changes nothing. A non-blocking push to a full receive FIFO drops the word, clears the register and its counter, and leaves the FIFO unchanged.
- R7: A blocking pull from an empty transmit FIFO raises stall. A non-blocking pull from an empty transmit FIFO loads xValue and clears the counter.
- R8: Direct loads (cmdOp 5 for input, 6 for output) write cmdData and clear the counter of that register.
- R9: With autoPush set, a shift-in whose new count reaches pushThresh pushes the shifted word and clears the register in the same cycle. If the receive FIFO is full, the shift-in stalls instead.
- R10: With autoPull set and the output count at or above pullThresh, a shift-out first loads the transmit head and then shifts from that word, so the count becomes N. If the transmit FIFO is empty, the shift-out stalls instead.
- R11: joinMode 0 gives each FIFO 4 entries. joinMode 1 gives the receive FIFO 8 entries and the transmit FIFO none, so it is always full. joinMode 2 gives the transmit FIFO 8 entries and the receive FIFO none, so it is always full.
- R12: A host write to a full transmit FIFO and a host read of an empty receive FIFO are ignored. Levels count entries, and rxRData shows the receive head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| shiftInRight | input | 1 | Input register shifts right when set |
| shiftOutRight | input | 1 | Output register shifts right when set |
| autoPush | input | 1 | Enable automatic push |
| autoPull | input | 1 | Enable automatic pull |
| pushThresh | input | 6 | Push threshold, 1..32 |
| pullThresh | input | 6 | Pull threshold, 1..32 |
| joinMode | input | 2 | FIFO join setting |
| cmdValid | input | 1 | Command strobe |
| cmdOp | input | 3 | Command code |
| cmdCount | input | 6 | Bit count, 1..32 |
| cmdData | input | 32 | Shift-in source or load value |
| cmdIfThresh | input | 1 | Push or pull only at threshold |
| cmdBlock | input | 1 | Push or pull blocks |
| xValue | input | 32 | Scratch value for a non-blocking empty pull |
| stall | output | 1 | Command cannot complete this cycle |
| shiftOutData | output | 32 | Bits released by shift-out |
| isrValue | output | 32 | Input shift register |
| osrValue | output | 32 | Output shift register |
| isrCount | output | 6 | Input shift counter |
| osrCount | output | 6 | Output shift counter |
| txWrite | input | 1 | Host write strobe |
| txWData | input | 32 | Host write data |
| txFull | output | 1 | Transmit FIFO full |
| txLevel | output | 4 | Transmit FIFO level |
| rxRead | input | 1 | Host read strobe |
| rxRData | output | 32 | Receive FIFO head |
| rxEmpty | output | 1 | Receive FIFO empty |
| rxLevel | output | 4 | Receive FIFO level |

## Verification
The hardest case to reach is an automatic transfer that meets a FIFO edge. One example is a shift-in that crosses the push threshold while the receive queue is already full. Another is a shift-out that needs a pull while the transmit queue has just drained. Directed sequences build these states on purpose: they fill the receive queue with threshold-sized shifts, then issue one more, and they drain the transmit queue with counted shifts. Seeded random commands with random host traffic then run under several direction, threshold and join settings. A queue model in the bench predicts every output.

// File: rtl/sfpPkg.sv
package sfpPkg;
  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_SHIN  = 3'd1,
    OP_SHOUT = 3'd2,
    OP_PUSH  = 3'd3,
    OP_PULL  = 3'd4,
    OP_LDISR = 3'd5,
    OP_LDOSR = 3'd6,
    OP_RSVD  = 3'd7
  } sfpOpE;

  typedef enum logic [1:0] {
    JOIN_NONE = 2'd0,
    JOIN_RX   = 2'd1,
    JOIN_TX   = 2'd2,
    JOIN_RSVD = 2'd3
  } sfpJoinE;

  typedef struct packed {
    logic isrShift;
    logic isrClear;
    logic isrLoad;
    logic osrShift;
    logic osrFromFifo;
    logic osrFromX;
    logic osrLoad;
    logic rxPush;
    logic txPop;
  } sfpStrobeS;
endpackage

// File: rtl/sfpFifo.sv
module sfpFifo #(
  parameter int W     = 32,
  parameter int SLOTS = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [$clog2(SLOTS+1)-1:0]   cap,
  input  logic                         wrEn,
  input  logic [W-1:0]                 wrData,
  input  logic                         rdEn,
  output logic [W-1:0]                 rdData,
  output logic [$clog2(SLOTS+1)-1:0]   level,
  output logic                         full,
  output logic                         empty
);
  localparam int PW = $clog2(SLOTS);
  localparam int LW = $clog2(SLOTS+1);

  logic [W-1:0]  mem [SLOTS];
  logic [PW-1:0] wrPtr, rdPtr;
  logic          wrOk, rdOk;

  assign full   = level >= cap;
  assign empty  = level == '0;
  assign wrOk   = wrEn && !full;
  assign rdOk   = rdEn && !empty;
  assign rdData = mem[rdPtr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (wrOk) wrPtr <= wrPtr + PW'(1);
      if (rdOk) rdPtr <= rdPtr + PW'(1);
      level <= level + LW'(wrOk) - LW'(rdOk);
    end
  end

  always_ff @(posedge clk) begin
    if (wrOk) mem[wrPtr] <= wrData;
  end
endmodule

// File: rtl/sfpDatapath.sv
module sfpDatapath
  import sfpPkg::*;
#(
  parameter int DW = 32,
  parameter int CW = $clog2(DW+1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  sfpStrobeS     st,
  input  logic          shiftInRight,
  input  logic          shiftOutRight,
  input  logic [CW-1:0] cnt,
  input  logic [DW-1:0] cmdData,
  input  logic [DW-1:0] xValue,
  input  logic [DW-1:0] txHead,
  output logic [DW-1:0] isr,
  output logic [DW-1:0] osr,
  output logic [CW-1:0] isrCount,
  output logic [CW-1:0] osrCount,
  output logic [DW-1:0] isrShifted,
  output logic [CW-1:0] isrCountNext,
  output logic [DW-1:0] shiftOutData
);
  function automatic logic [CW-1:0] satAdd(logic [CW-1:0] a, logic [CW-1:0] b);
    logic [CW:0] s;
    s = {1'b0, a} + {1'b0, b};
    return (s > (CW+1)'(DW)) ? CW'(DW) : s[CW-1:0];
  endfunction

  logic [DW-1:0] ones, mask, osrSrc, osrShifted;
  logic [CW-1:0] osrCountNext, rest;

  assign ones = '1;

  always_comb begin
    mask         = ~(ones << cnt);
    rest         = CW'(DW) - cnt;
    isrShifted   = shiftInRight ? ((isr >> cnt) | (cmdData << rest))
                                : ((isr << cnt) | (cmdData & mask));
    isrCountNext = satAdd(isrCount, cnt);
    osrSrc       = st.osrFromFifo ? txHead : osr;
    shiftOutData = shiftOutRight ? (osrSrc & mask) : (osrSrc >> rest);
    osrShifted   = shiftOutRight ? (osrSrc >> cnt) : (osrSrc << cnt);
    osrCountNext = satAdd(st.osrFromFifo ? '0 : osrCount, cnt);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      isr      <= '0;
      isrCount <= '0;
    end else if (st.isrClear) begin
      isr      <= '0;
      isrCount <= '0;
    end else if (st.isrLoad) begin
      isr      <= cmdData;
      isrCount <= '0;
    end else if (st.isrShift) begin
      isr      <= isrShifted;
      isrCount <= isrCountNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      osr      <= '0;
      osrCount <= '0;
    end else if (st.osrShift) begin
      osr      <= osrShifted;
      osrCount <= osrCountNext;
    end else if (st.osrFromFifo) begin
      osr      <= txHead;
      osrCount <= '0;
    end else if (st.osrFromX) begin
      osr      <= xValue;
      osrCount <= '0;
    end else if (st.osrLoad) begin
      osr      <= cmdData;
      osrCount <= '0;
    end
  end
endmodule

// File: rtl/sfpControl.sv
module sfpControl
  import sfpPkg::*;
#(
  parameter int CW = 6
) (
  input  logic          cmdValid,
  input  sfpOpE         op,
  input  logic          ifThresh,
  input  logic          block,
  input  logic          autoPush,
  input  logic          autoPull,
  input  logic [CW-1:0] pushThresh,
  input  logic [CW-1:0] pullThresh,
  input  logic [CW-1:0] isrCount,
  input  logic [CW-1:0] osrCount,
  input  logic [CW-1:0] isrCountNext,
  input  logic          rxFull,
  input  logic          txEmpty,
  output sfpStrobeS     st,
  output logic          stall
);
  always_comb begin
    st    = '0;
    stall = 1'b0;
    if (cmdValid) begin
      unique case (op)
        OP_SHIN: begin
          if (autoPush && isrCountNext >= pushThresh) begin
            if (rxFull) stall = 1'b1;
            else begin
              st.isrShift = 1'b1;
              st.rxPush   = 1'b1;
              st.isrClear = 1'b1;
            end
          end else st.isrShift = 1'b1;
        end
        OP_SHOUT: begin
          if (autoPull && osrCount >= pullThresh) begin
            if (txEmpty) stall = 1'b1;
            else begin
              st.osrFromFifo = 1'b1;
              st.txPop       = 1'b1;
              st.osrShift    = 1'b1;
            end
          end else st.osrShift = 1'b1;
        end
        OP_PUSH: begin
          if (!(ifThresh && isrCount < pushThresh)) begin
            if (rxFull) begin
              if (block) stall = 1'b1;
              else st.isrClear = 1'b1;
            end else begin
              st.rxPush   = 1'b1;
              st.isrClear = 1'b1;
            end
          end
        end
        OP_PULL: begin
          if (!(ifThresh && osrCount < pullThresh)) begin
            if (txEmpty) begin
              if (block) stall = 1'b1;
              else st.osrFromX = 1'b1;
            end else begin
              st.osrFromFifo = 1'b1;
              st.txPop       = 1'b1;
            end
          end
        end
        OP_LDISR: st.isrLoad = 1'b1;
        OP_LDOSR: st.osrLoad = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/shiftFifoPath.sv
module shiftFifoPath
  import sfpPkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  parameter int CW    = $clog2(DW+1),
  parameter int LW    = $clog2(2*DEPTH+1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          shiftInRight,
  input  logic          shiftOutRight,
  input  logic          autoPush,
  input  logic          autoPull,
  input  logic [CW-1:0] pushThresh,
  input  logic [CW-1:0] pullThresh,
  input  logic [1:0]    joinMode,
  input  logic          cmdValid,
  input  logic [2:0]    cmdOp,
  input  logic [CW-1:0] cmdCount,
  input  logic [DW-1:0] cmdData,
  input  logic          cmdIfThresh,
  input  logic          cmdBlock,
  input  logic [DW-1:0] xValue,
  output logic          stall,
  output logic [DW-1:0] shiftOutData,
  output logic [DW-1:0] isrValue,
  output logic [DW-1:0] osrValue,
  output logic [CW-1:0] isrCount,
  output logic [CW-1:0] osrCount,
  input  logic          txWrite,
  input  logic [DW-1:0] txWData,
  output logic          txFull,
  output logic [LW-1:0] txLevel,
  input  logic          rxRead,
  output logic [DW-1:0] rxRData,
  output logic          rxEmpty,
  output logic [LW-1:0] rxLevel
);
  localparam int SLOTS = 2 * DEPTH;

  sfpStrobeS     st;
  logic [LW-1:0] rxCap, txCap;
  logic [DW-1:0] txHead, isrShifted, rxWData;
  logic [CW-1:0] isrCountNext;
  logic          rxFull, txEmpty;

  always_comb begin
    unique case (sfpJoinE'(joinMode))
      JOIN_RX: begin rxCap = LW'(SLOTS); txCap = '0;           end
      JOIN_TX: begin rxCap = '0;           txCap = LW'(SLOTS); end
      default: begin rxCap = LW'(DEPTH);   txCap = LW'(DEPTH); end
    endcase
  end

  assign rxWData = st.isrShift ? isrShifted : isrValue;

  sfpControl #(.CW(CW)) ctrl_i (
    .cmdValid(cmdValid), .op(sfpOpE'(cmdOp)), .ifThresh(cmdIfThresh), .block(cmdBlock),
    .autoPush(autoPush), .autoPull(autoPull), .pushThresh(pushThresh), .pullThresh(pullThresh),
    .isrCount(isrCount), .osrCount(osrCount), .isrCountNext(isrCountNext),
    .rxFull(rxFull), .txEmpty(txEmpty), .st(st), .stall(stall)
  );

  sfpDatapath #(.DW(DW), .CW(CW)) dp_i (
    .clk(clk), .rstN(rstN), .st(st), .shiftInRight(shiftInRight), .shiftOutRight(shiftOutRight),
    .cnt(cmdCount), .cmdData(cmdData), .xValue(xValue), .txHead(txHead),
    .isr(isrValue), .osr(osrValue), .isrCount(isrCount), .osrCount(osrCount),
    .isrShifted(isrShifted), .isrCountNext(isrCountNext), .shiftOutData(shiftOutData)
  );

  sfpFifo #(.W(DW), .SLOTS(SLOTS)) rxFifo_i (
    .clk(clk), .rstN(rstN), .cap(rxCap), .wrEn(st.rxPush), .wrData(rxWData),
    .rdEn(rxRead), .rdData(rxRData), .level(rxLevel), .full(rxFull), .empty(rxEmpty)
  );

  sfpFifo #(.W(DW), .SLOTS(SLOTS)) txFifo_i (
    .clk(clk), .rstN(rstN), .cap(txCap), .wrEn(txWrite), .wrData(txWData),
    .rdEn(st.txPop), .rdData(txHead), .level(txLevel), .full(txFull), .empty(txEmpty)
  );
endmodule

// File: rtl/shiftFifoPath_chk.sv
module shiftFifoPath_chk #(
  parameter int DW = 32,
  parameter int CW = 6,
  parameter int LW = 4
) (
  input logic          clk,
  input logic          rstN,
  input logic          cmdValid,
  input logic [2:0]    cmdOp,
  input logic [DW-1:0] cmdData,
  input logic          cmdIfThresh,
  input logic [1:0]    joinMode,
  input logic          stall,
  input logic [DW-1:0] isrValue,
  input logic [DW-1:0] osrValue,
  input logic [CW-1:0] isrCount,
  input logic [CW-1:0] osrCount,
  input logic [LW-1:0] txLevel,
  input logic [LW-1:0] rxLevel,
  input logic          rxEmpty
);
  AST_ISR_SATURATES: assert property (@(posedge clk) disable iff (!rstN) isrCount <= CW'(DW)); // R2
  AST_OSR_SATURATES: assert property (@(posedge clk) disable iff (!rstN) osrCount <= CW'(DW)); // R3
  AST_PUSH_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdOp == 3'd3 && !cmdIfThresh && !stall |=> isrValue == '0 && isrCount == '0); // R4
  AST_STALL_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rstN) stall |-> cmdValid); // R6
  AST_STALL_FREEZES: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> $stable(isrValue) && $stable(osrValue) && $stable(isrCount) && $stable(osrCount)); // R6
  AST_PULL_STALL_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdOp == 3'd4 && stall |-> txLevel == '0); // R7
  AST_LOAD_OSR: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdOp == 3'd6 |=> osrCount == '0 && osrValue == $past(cmdData)); // R8
  AST_JOIN_RX_NO_TX: assert property (@(posedge clk) disable iff (!rstN)
    joinMode == 2'd1 |-> txLevel == '0); // R11
  AST_RX_EMPTY_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    rxEmpty |-> rxLevel == '0); // R12
endmodule

bind shiftFifoPath shiftFifoPath_chk #(.DW(DW), .CW(CW), .LW(LW)) chk_i (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdData(cmdData),
  .cmdIfThresh(cmdIfThresh), .joinMode(joinMode), .stall(stall), .isrValue(isrValue),
  .osrValue(osrValue), .isrCount(isrCount), .osrCount(osrCount), .txLevel(txLevel),
  .rxLevel(rxLevel), .rxEmpty(rxEmpty)
);

// File: tb/shiftFifoPath_tb_top.sv
`timescale 1ns/1ps
module shiftFifoPath_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN, shiftInRight, shiftOutRight, autoPush, autoPull;
  logic [5:0] pushThresh, pullThresh, cmdCount, isrCount, osrCount;
  logic [1:0] joinMode;
  logic cmdValid, cmdIfThresh, cmdBlock, stall, txWrite, txFull, rxRead, rxEmpty;
  logic [2:0] cmdOp;
  logic [31:0] cmdData, xValue, shiftOutData, isrValue, osrValue, txWData, rxRData;
  logic [3:0] txLevel, rxLevel;

  shiftFifoPath dut_i (.*);

  int nChecks = 0, nFail = 0;
  logic [31:0] mIsr, mOsr;
  int mIc, mOc, rxCap, txCap;
  logic [31:0] rxQ[$], txQ[$];
  string tagOverride = "";

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic int sat(int v);
    return (v > 32) ? 32 : v;
  endfunction

  function automatic logic [31:0] shinF(logic [31:0] v, logic [31:0] d, int n, bit right);
    logic [31:0] r;
    for (int i = 0; i < 32; i++)
      if (!right) r[i] = (i < n) ? d[i] : v[i-n];
      else        r[i] = (i >= 32-n) ? d[i-32+n] : v[i+n];
    return r;
  endfunction

  function automatic logic [31:0] shoutVal(logic [31:0] v, int n, bit right);
    logic [31:0] r = '0;
    for (int j = 0; j < n; j++) r[j] = right ? v[j] : v[32-n+j];
    return r;
  endfunction

  function automatic logic [31:0] shoutRest(logic [31:0] v, int n, bit right);
    logic [31:0] r;
    for (int i = 0; i < 32; i++)
      if (right) r[i] = (i + n < 32) ? v[i+n] : 1'b0;
      else       r[i] = (i >= n) ? v[i-n] : 1'b0;
    return r;
  endfunction

  task automatic doReset(bit inR, bit outR, bit aPush, bit aPull, int pT, int qT, int jm);
    rstN = 1'b0; cmdValid = 0; cmdOp = 0; cmdCount = 1; cmdData = 0; cmdIfThresh = 0;
    cmdBlock = 0; txWrite = 0; txWData = 0; rxRead = 0; xValue = 32'hCAFEF00D;
    shiftInRight = inR; shiftOutRight = outR; autoPush = aPush; autoPull = aPull;
    pushThresh = 6'(pT); pullThresh = 6'(qT); joinMode = 2'(jm);
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    mIsr = 0; mOsr = 0; mIc = 0; mOc = 0; rxQ.delete(); txQ.delete();
    rxCap = (jm == 1) ? 8 : (jm == 2) ? 0 : 4;
    txCap = (jm == 2) ? 8 : (jm == 1) ? 0 : 4;
    #1;
    check("R1", "isrValue", isrValue, 0);
    check("R1", "osrValue", osrValue, 0);
    check("R1", "counts", {isrCount, osrCount}, 0);
    check("R1", "levels", {rxLevel, txLevel}, 0);
    check("R1", "rxEmpty", rxEmpty, 1);
  endtask

  task automatic step(int op, int cnt, logic [31:0] d, bit ifT, bit blk, bit hw, logic [31:0] hwd, bit hr);
    bit rxFullP, txEmptyP, txFullP, hrOk, eStall, doRx, doPop, ok;
    logic [31:0] nIsr, nOsr, rxVal, eOut, src, tIsr;
    int nIc, nOc, tIc, base;
    string tg;
    @(negedge clk);
    cmdValid = (op != 0); cmdOp = 3'(op); cmdCount = 6'(cnt); cmdData = d;
    cmdIfThresh = ifT; cmdBlock = blk; txWrite = hw; txWData = hwd; rxRead = hr;
    rxFullP = rxQ.size() >= rxCap; txEmptyP = txQ.size() == 0; txFullP = txQ.size() >= txCap;
    hrOk = hr && rxQ.size() > 0;
    nIsr = mIsr; nOsr = mOsr; nIc = mIc; nOc = mOc;
    eStall = 0; doRx = 0; doPop = 0; eOut = 0; rxVal = 0;
    case (op)
      1: begin
        tIc = sat(mIc + cnt); tIsr = shinF(mIsr, d, cnt, shiftInRight);
        if (autoPush && tIc >= int'(pushThresh)) begin
          if (rxFullP) eStall = 1;
          else begin doRx = 1; rxVal = tIsr; nIsr = 0; nIc = 0; end
        end else begin nIsr = tIsr; nIc = tIc; end
      end
      2: begin
        src = mOsr; base = mOc; ok = 1;
        if (autoPull && mOc >= int'(pullThresh)) begin
          if (txEmptyP) begin eStall = 1; ok = 0; end
          else begin src = txQ[0]; base = 0; doPop = 1; end
        end
        if (ok) begin
          eOut = shoutVal(src, cnt, shiftOutRight);
          nOsr = shoutRest(src, cnt, shiftOutRight);
          nOc = sat(base + cnt);
        end
      end
      3: if (!(ifT && mIc < int'(pushThresh))) begin
        if (rxFullP) begin
          if (blk) eStall = 1; else begin nIsr = 0; nIc = 0; end
        end else begin doRx = 1; rxVal = mIsr; nIsr = 0; nIc = 0; end
      end
      4: if (!(ifT && mOc < int'(pullThresh))) begin
        if (txEmptyP) begin
          if (blk) eStall = 1; else begin nOsr = xValue; nOc = 0; end
        end else begin nOsr = txQ[0]; doPop = 1; nOc = 0; end
      end
      5: begin nIsr = d; nIc = 0; end
      6: begin nOsr = d; nOc = 0; end
      default: ;
    endcase
    case (op)
      1: tg = autoPush ? "R9" : "R2";
      2: tg = autoPull ? "R10" : "R3";
      3: tg = rxFullP ? "R6" : "R4";
      4: tg = txEmptyP ? "R7" : "R5";
      5, 6: tg = "R8";
      default: tg = "R12";
    endcase
    if (tagOverride != "") tg = tagOverride;
    #1;
    check(tg, "stall", stall, eStall);
    if (op == 2 && !eStall) check(tg, "shiftOutData", shiftOutData, eOut);
    if (hrOk) check("R12", "rxRData", rxRData, rxQ[0]);
    @(posedge clk);
    mIsr = nIsr; mOsr = nOsr; mIc = nIc; mOc = nOc;
    if (doPop) void'(txQ.pop_front());
    if (hw && !txFullP) txQ.push_back(hwd);
    if (hrOk) void'(rxQ.pop_front());
    if (doRx) rxQ.push_back(rxVal);
    #1;
    check(tg, "isrValue", isrValue, mIsr);
    check(tg, "osrValue", osrValue, mOsr);
    check(tg, "isrCount", 32'(isrCount), 32'(mIc));
    check(tg, "osrCount", 32'(osrCount), 32'(mOc));
    check(tg, "rxLevel", 32'(rxLevel), 32'(rxQ.size()));
    check(tg, "txLevel", 32'(txLevel), 32'(txQ.size()));
    check(tg, "txFull", txFull, txQ.size() >= txCap);
    check(tg, "rxEmpty", rxEmpty, rxQ.size() == 0);
  endtask

  task automatic randomRun(int n);
    for (int i = 0; i < n; i++)
      step($urandom_range(0, 7), $urandom_range(1, 32), $urandom, 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 1)), $urandom_range(0, 9) < 5, $urandom, $urandom_range(0, 9) < 4);
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL R1 watchdog: actual=running expected=finished");
    finishRun();
  end

  initial begin
    void'($urandom(32'd2718));
    // R2 R3 R4 R5 R6 R7 R8 R12 directed, left shifts, no automatic transfer
    doReset(0, 0, 0, 0, 8, 8, 0);
    step(1, 8, 32'h000000A5, 0, 0, 0, 0, 0);
    step(1, 32, 32'h12345678, 0, 0, 0, 0, 0);
    step(1, 4, 32'hFFFFFFFF, 0, 0, 0, 0, 0);
    step(3, 1, 0, 0, 1, 0, 0, 0);
    step(3, 1, 0, 1, 1, 0, 0, 0);
    step(5, 1, 32'hDEADBEEF, 0, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0, 0, 0, 1);
    step(0, 1, 0, 0, 0, 1, 32'h11111111, 0);
    step(0, 1, 0, 0, 0, 1, 32'h22222222, 0);
    step(0, 1, 0, 0, 0, 1, 32'h33333333, 0);
    step(4, 1, 0, 0, 1, 0, 0, 0);
    step(4, 1, 0, 1, 1, 0, 0, 0);
    step(2, 4, 0, 0, 0, 0, 0, 0);
    step(2, 32, 0, 0, 0, 0, 0, 0);
    step(4, 1, 0, 1, 1, 0, 0, 0);
    for (int k = 0; k < 4; k++) begin
      step(5, 1, 32'hA0 + k, 0, 0, 0, 0, 0);
      step(3, 1, 0, 0, 1, 0, 0, 0);
    end
    step(5, 1, 32'h99, 0, 0, 0, 0, 0);
    step(3, 1, 0, 0, 1, 0, 0, 0);
    step(3, 1, 0, 0, 0, 0, 0, 0);
    for (int k = 0; k < 5; k++) step(0, 1, 0, 0, 0, 0, 0, 1);
    step(4, 1, 0, 0, 1, 0, 0, 0);
    step(4, 1, 0, 0, 1, 0, 0, 0);
    step(4, 1, 0, 0, 0, 0, 0, 0);
    for (int k = 0; k < 5; k++) step(0, 1, 0, 0, 0, 1, 32'h50 + k, 0);
    step(6, 1, 32'h0F0F0F0F, 0, 0, 0, 0, 0);
    // R9 R10 directed, right shifts, automatic transfers
    doReset(1, 1, 1, 1, 12, 16, 0);
    step(1, 8, 32'hAB, 0, 0, 0, 0, 0);
    step(1, 8, 32'hCD, 0, 0, 0, 0, 0);
    for (int k = 0; k < 4; k++) step(1, 12, 32'h123 * (k + 1), 0, 0, 0, 0, 0);
    step(2, 8, 0, 0, 0, 0, 0, 0);
    step(2, 8, 0, 0, 0, 0, 0, 0);
    step(2, 4, 0, 0, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0, 1, 32'h89ABCDEF, 0);
    step(2, 4, 0, 0, 0, 0, 0, 0);
    // seeded random under several settings
    doReset(0, 0, 0, 0, 16, 16, 0); randomRun(300);
    doReset(1, 0, 1, 1, 32, 8, 0);  randomRun(300);
    doReset(0, 1, 1, 1, 5, 27, 0);  randomRun(300);
    doReset(1, 1, 1, 0, 1, 1, 0);   randomRun(300);
    // R11 join settings
    doReset(0, 0, 0, 0, 32, 32, 1);
    tagOverride = "R11";
    for (int k = 0; k < 9; k++) begin
      step(5, 1, 32'h700 + k, 0, 0, 0, 0, 0);
      step(3, 1, 0, 0, 0, 1, 32'h1, 0);
    end
    tagOverride = ""; randomRun(150);
    doReset(0, 0, 0, 0, 32, 32, 2);
    tagOverride = "R11";
    for (int k = 0; k < 9; k++) step(0, 1, 0, 0, 0, 1, 32'h800 + k, 0);
    step(3, 1, 0, 0, 1, 0, 0, 0);
    tagOverride = ""; randomRun(150);
    @(negedge clk); cmdValid = 0; txWrite = 0; rxRead = 0;
    finishRun();
  end
endmodule